// File: doc/BRIEF.md
# Accumulator-Ticked Timer with Fixed-Interval Pulse Outputs

The block keeps a nanosecond time of day and derives two periodic pulse trains from it. A 32-bit phase accumulator adds a programmable addend on every clock while the block is enabled. Each carry out of that addition is a timer tick. On every tick a 64-bit nanosecond counter advances by a programmable tick period. This lets a clock of any frequency drive a time base with a fixed step, and the step rate is trimmed by changing the addend.

Two pulse channels share the same ticks. Each channel holds a down counter that is preloaded from its interval register. On every tick the counter drops by the tick period, not by one. When it reaches zero the channel drives its output high for one clock, and the counter is reloaded in the cycle after that. A tick that lands in the reload cycle is not applied, so the pulse spacing is the interval plus one tick period. For a one-second train with a 5 ns period, software programs 999 999 995.

Each channel runs a three-state machine. HALT preloads the counter while the block is disabled, and goes to COUNT when enabled. COUNT decrements on ticks and goes to RELOAD on the tick that reaches zero. RELOAD drives the pulse, refills the counter and returns to COUNT. Any state goes to HALT when the enable is low. All settings are written through a single-cycle write port.

Top module: `fip_timer_top`

## Requirements
- R1: After reset, the nanosecond counter is 0, both pulse outputs are low, the enable is off and no tick is produced. Reset loads these defaults: addend 0xAAAAAAAB, tick period 5, interval of channel 0 999999995, interval of channel 1 99990.
- R2: While enabled, the accumulator adds the addend on every clock, starting from 0, and `tick_o` is high in exactly the cycles whose addition carries out of bit 31. With the default addend, 300 enabled clocks give 200 ticks.
- R3: On each tick, the nanosecond counter adds the tick period at the next clock edge.
- R4: Each channel's down counter is loaded from its interval and drops by the tick period on each tick. The channel pulses when the counter reaches zero. With a tick on every clock, pulses repeat every (interval + period) / period clocks, for example every 5 clocks for interval 20 and period 5.
- R5: A decrement that would take the counter below zero sets it to zero and produces the pulse, with no wrap. With interval 12 and period 5, the pulses are 4 clocks apart.
- R6: A pulse is high for exactly one clock. The counter is reloaded from the interval register in that pulse cycle's following edge, and a tick in the pulse cycle is not counted.
- R7: While the enable is low, the accumulator and nanosecond counter hold, `tick_o` and both pulses stay low, and both down counters are preloaded. After re-enabling with interval 45 and a tick every clock, the first pulse is seen between 9 and 12 clocks after the enabling write.
- R8: An interval written while the block is enabled leaves the countdown in progress unchanged and is used from the next reload on.
- R9: A write takes effect at the clock edge that samples `wr_en` high. `wr_sel` selects the target: 0 for the addend, 1 for the tick period (low 8 bits), 2 for the channel 0 interval, 3 for the channel 1 interval and 4 for the enable (bit 0). Other codes have no effect.
- R10: The two channels count independently. A write to one channel's interval does not change the other channel's pulse spacing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| wr_en | input | 1 | Write strobe |
| wr_sel | input | 3 | Write target select |
| wr_data | input | 32 | Write data |
| tick_o | output | 1 | Timer tick strobe (accumulator carry) |
| time_ns_o | output | 64 | Nanosecond time counter |
| pulse_o | output | 2 | One-clock pulses, bit i for channel i |

## Verification
The default addend is run for 300 clocks, and the tick count and final time show whether the carry is taken from the accumulator or the tick fires on every clock. An all-ones addend gives a tick on nearly every clock. With it, interval 20 separates subtraction of the period from subtraction of one and shows the lost reload tick. Interval 12 separates clamping from a wrapping underflow. A mid-run interval rewrite shows whether the new value reaches the countdown in progress or waits for the next reload. A disable and re-enable shows holding and preloading.

// File: rtl/fip_pkg.sv
package fip_pkg;

    // write-port targets
    localparam logic [2:0] SEL_ADDEND = 3'd0;
    localparam logic [2:0] SEL_PERIOD = 3'd1;
    localparam logic [2:0] SEL_INTV0  = 3'd2;
    localparam logic [2:0] SEL_INTV1  = 3'd3;
    localparam logic [2:0] SEL_ENABLE = 3'd4;

    // per-channel countdown machine
    typedef enum logic [1:0] {
        ST_HALT   = 2'd0,
        ST_COUNT  = 2'd1,
        ST_RELOAD = 2'd2
    } pulser_state_t;

endpackage

// File: rtl/fip_tick_accum.sv
module fip_tick_accum #(
    parameter int ACC_W  = 32,
    parameter int TIME_W = 64,
    parameter int PER_W  = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              en_i,
    input  logic [ACC_W-1:0]  addend_i,
    input  logic [PER_W-1:0]  period_i,
    output logic              tick_o,
    output logic [TIME_W-1:0] time_o
);

    localparam int EXT_W = TIME_W - PER_W;

    logic [ACC_W-1:0]  acc_q;
    logic [ACC_W:0]    sum;
    logic [TIME_W-1:0] step;
    logic [TIME_W-1:0] time_q;

    assign sum    = {1'b0, acc_q} + {1'b0, addend_i};
    assign tick_o = en_i & sum[ACC_W];
    assign step   = {{EXT_W{1'b0}}, period_i};
    assign time_o = time_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc_q  <= '0;
            time_q <= '0;
        end else begin
            if (en_i)
                acc_q <= sum[ACC_W-1:0];
            if (tick_o)
                time_q <= time_q + step;
        end
    end

    // R3: each tick moves time by one period
    a_r3_time_step: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> time_q == $past(time_q) + $past(step));

    // R7: disabled means frozen time and phase
    a_r7_time_hold: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> $stable(time_q) && $stable(acc_q));

endmodule

// File: rtl/fip_pulser.sv
module fip_pulser
    import fip_pkg::*;
#(
    parameter int CNT_W = 32,
    parameter int PER_W = 8
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  logic             tick_i,
    input  logic [PER_W-1:0] period_i,
    input  logic [CNT_W-1:0] interval_i,
    output logic             pulse_o
);

    localparam int EXT_W = CNT_W - PER_W;

    pulser_state_t   state_q, state_d;
    logic [CNT_W-1:0] cnt_q;
    logic [CNT_W-1:0] dec;
    logic             hit;
    logic             pulse_q;

    assign dec     = {{EXT_W{1'b0}}, period_i};
    assign hit     = (cnt_q <= dec);
    assign pulse_o = pulse_q;

    // next state
    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_HALT:   state_d = en_i ? ST_COUNT : ST_HALT;
            ST_COUNT:  if (!en_i)             state_d = ST_HALT;
                       else if (tick_i && hit) state_d = ST_RELOAD;
            ST_RELOAD: state_d = en_i ? ST_COUNT : ST_HALT;
            default:   state_d = ST_HALT;
        endcase
    end

    // state register
    always_ff @(posedge clk) begin
        if (!rst_n) state_q <= ST_HALT;
        else        state_q <= state_d;
    end

    // counter and pulse
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cnt_q   <= interval_i;
            pulse_q <= 1'b0;
        end else begin
            pulse_q <= 1'b0;
            unique case (state_q)
                ST_HALT:   cnt_q <= interval_i;
                ST_COUNT:  if (en_i && tick_i) begin
                               if (hit) begin
                                   cnt_q   <= '0;
                                   pulse_q <= 1'b1;
                               end else begin
                                   cnt_q <= cnt_q - dec;
                               end
                           end
                ST_RELOAD: cnt_q <= interval_i;
                default:   cnt_q <= interval_i;
            endcase
        end
    end

    // R6: one clock wide
    a_r6_single_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> !pulse_q);

    // R6: refill on the edge after the pulse cycle
    a_r6_reload_after: assert property (@(posedge clk) disable iff (!rst_n)
        pulse_q |=> cnt_q == $past(interval_i));

    // R4: ordinary tick takes one period away
    a_r4_decrement: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && en_i && tick_i && !hit)
        |=> cnt_q == $past(cnt_q) - $past(dec) && !pulse_q);

    // R5: final tick lands at zero, never wraps
    a_r5_no_wrap: assert property (@(posedge clk) disable iff (!rst_n)
        (state_q == ST_COUNT && en_i && tick_i && hit) |=> cnt_q == '0 && pulse_q);

    // R7: no pulse after a disabled cycle
    a_r7_quiet_off: assert property (@(posedge clk) disable iff (!rst_n)
        !en_i |=> !pulse_q);

endmodule

// File: rtl/fip_timer_top.sv
module fip_timer_top
    import fip_pkg::*;
#(
    parameter int          ACC_W      = 32,
    parameter int          TIME_W     = 64,
    parameter int          CNT_W      = 32,
    parameter int          PER_W      = 8,
    parameter int          DATA_W     = 32,
    parameter logic [31:0] ADDEND_RST = 32'hAAAA_AAAB,
    parameter int          PERIOD_RST = 5,
    parameter int          INTV0_RST  = 999_999_995,
    parameter int          INTV1_RST  = 99_990
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  logic [2:0]        wr_sel,
    input  logic [DATA_W-1:0] wr_data,
    output logic              tick_o,
    output logic [TIME_W-1:0] time_ns_o,
    output logic [1:0]        pulse_o
);

    localparam int NUM_CH = 2;

    logic [ACC_W-1:0] addend_q;
    logic [PER_W-1:0] period_q;
    logic [CNT_W-1:0] intv_q [NUM_CH];
    logic             en_q;
    logic             tick;

    // write port
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addend_q  <= ADDEND_RST[ACC_W-1:0];
            period_q  <= PER_W'(PERIOD_RST);
            intv_q[0] <= CNT_W'(INTV0_RST);
            intv_q[1] <= CNT_W'(INTV1_RST);
            en_q      <= 1'b0;
        end else if (wr_en) begin
            case (wr_sel)
                SEL_ADDEND: addend_q  <= wr_data[ACC_W-1:0];
                SEL_PERIOD: period_q  <= wr_data[PER_W-1:0];
                SEL_INTV0:  intv_q[0] <= wr_data[CNT_W-1:0];
                SEL_INTV1:  intv_q[1] <= wr_data[CNT_W-1:0];
                SEL_ENABLE: en_q      <= wr_data[0];
                default:    ;
            endcase
        end
    end

    fip_tick_accum #(
        .ACC_W  (ACC_W),
        .TIME_W (TIME_W),
        .PER_W  (PER_W)
    ) u_accum (
        .clk      (clk),
        .rst_n    (rst_n),
        .en_i     (en_q),
        .addend_i (addend_q),
        .period_i (period_q),
        .tick_o   (tick),
        .time_o   (time_ns_o)
    );

    assign tick_o = tick;

    for (genvar g = 0; g < NUM_CH; g++) begin : g_ch
        fip_pulser #(
            .CNT_W (CNT_W),
            .PER_W (PER_W)
        ) u_pulser (
            .clk        (clk),
            .rst_n      (rst_n),
            .en_i       (en_q),
            .tick_i     (tick),
            .period_i   (period_q),
            .interval_i (intv_q[g]),
            .pulse_o    (pulse_o[g])
        );
    end

    // R9: write to the enable lands on the next edge
    a_r9_enable_write: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && wr_sel == SEL_ENABLE) |=> en_q == $past(wr_data[0]));

    // R2: no tick while disabled
    a_r2_idle_no_tick: assert property (@(posedge clk) disable iff (!rst_n)
        !en_q |-> !tick_o);

endmodule

// File: tb/sim_fip_timer_top.sv
module sim_fip_timer_top;

    logic        clk = 1'b0;
    logic        rst_n;
    logic        wr_en;
    logic [2:0]  wr_sel;
    logic [31:0] wr_data;
    logic        tick_o;
    logic [63:0] time_ns_o;
    logic [1:0]  pulse_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #5 clk = ~clk;

    fip_timer_top u0 (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en     (wr_en),
        .wr_sel    (wr_sel),
        .wr_data   (wr_data),
        .tick_o    (tick_o),
        .time_ns_o (time_ns_o),
        .pulse_o   (pulse_o)
    );

    task automatic check(input bit ok, input string req, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", req, act, exp);
        end
    endtask

    task automatic wr(input logic [2:0] sel, input logic [31:0] d);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_data = d;
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic do_reset();
        wr_en = 1'b0; wr_sel = '0; wr_data = '0;
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
    endtask

    // R1
    task automatic t_reset();
        do_reset();
        repeat (4) @(negedge clk);
        check(time_ns_o == 0, "R1 time", longint'(time_ns_o), 0);
        check(pulse_o == 0, "R1 pulses", longint'(pulse_o), 0);
        check(tick_o == 0, "R1 tick", longint'(tick_o), 0);
    endtask

    // R2, R3, R1 defaults, R9 enable
    task automatic t_default_rate();
        int ticks = 0;
        do_reset();
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd4; wr_data = 32'd1;
        for (int k = 0; k < 300; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            ticks += int'(tick_o);
        end
        @(negedge clk);
        check(ticks == 200, "R2 tick count", ticks, 200);
        check(time_ns_o == 64'(5 * ticks), "R3 time", longint'(time_ns_o), 5 * ticks);
        check(time_ns_o == 1000, "R1 default period", longint'(time_ns_o), 1000);
    endtask

    // R4, R5, R6, R9, then R8, R10, R7
    task automatic t_pulse_spacing();
        int last0 = -1, last1 = -1, bad0 = 0, bad1 = 0, cnt0 = 0, cnt1 = 0;
        int p [3];
        int np = 0;
        int bad1b = 0;
        int first = -1;
        longint snap;
        int quiet_bad = 0;
        do_reset();
        wr(3'd0, 32'hFFFF_FFFF);
        wr(3'd1, 32'd5);
        wr(3'd2, 32'd20);
        wr(3'd3, 32'd12);
        wr(3'd7, 32'd1);      // unused code: no effect
        wr(3'd4, 32'd1);
        for (int k = 0; k < 80; k++) begin
            @(negedge clk);
            if (pulse_o[0]) begin
                if (last0 >= 0 && k - last0 != 5) bad0++;
                last0 = k; cnt0++;
            end
            if (pulse_o[1]) begin
                if (last1 >= 0 && k - last1 != 4) bad1++;
                last1 = k; cnt1++;
            end
        end
        check(bad0 == 0, "R4 spacing ch0", bad0, 0);
        check(cnt0 >= 14, "R4 pulse count ch0", cnt0, 14);
        check(bad1 == 0, "R5 clamp spacing ch1", bad1, 0);
        check(cnt1 >= 18, "R6 pulse count ch1", cnt1, 18);

        // R8: live rewrite of channel 0
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd2; wr_data = 32'd45;
        last1 = -1;
        for (int k = 1; k <= 60; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (pulse_o[0] && np < 3) begin p[np] = k; np++; end
            if (pulse_o[1]) begin
                if (last1 >= 0 && k - last1 != 4) bad1b++;
                last1 = k;
            end
        end
        check(np == 3, "R8 pulses seen", np, 3);
        check(p[0] <= 5, "R8 old countdown kept", p[0], 5);
        check(p[1] - p[0] == 10, "R8 new spacing", p[1] - p[0], 10);
        check(p[2] - p[1] == 10, "R8 new spacing 2", p[2] - p[1], 10);
        check(bad1b == 0, "R10 ch1 unaffected", bad1b, 0);

        // R7: disable and hold
        wr(3'd4, 32'd0);
        repeat (2) @(negedge clk);
        snap = longint'(time_ns_o);
        for (int k = 0; k < 20; k++) begin
            @(negedge clk);
            if (pulse_o != 0 || tick_o) quiet_bad++;
        end
        check(longint'(time_ns_o) == snap, "R7 time hold", longint'(time_ns_o), snap);
        check(quiet_bad == 0, "R7 outputs quiet", quiet_bad, 0);

        // R7: preload seen after re-enable
        @(negedge clk);
        wr_en = 1'b1; wr_sel = 3'd4; wr_data = 32'd1;
        for (int k = 1; k <= 20; k++) begin
            @(negedge clk);
            wr_en = 1'b0;
            if (pulse_o[0] && first < 0) first = k;
        end
        check(first >= 9 && first <= 12, "R7 first pulse after re-enable", first, 11);
    endtask

    initial begin
        t_reset();
        t_default_rate();
        t_pulse_spacing();
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

    initial begin
        #1_000_000;
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_fail);
        $finish;
    end

endmodule